// File: doc/BRIEF.md
# Ramp-Comparison Column Switch Timer

This block produces the sample-switch enables for a display column driver that builds its analog levels from one shared ramp, with no voltage converter per column. Six-bit pixel codes arrive one per clock and are written into an input register, one column after another. A line strobe copies the whole input register into a storage register and starts a single shared 6-bit sweep counter from zero. Each column's switch enable is high while that column should follow the ramp. It drops, and stays low for the rest of the sweep, at the count that equals the bitwise inverse of the column's stored code. That count is the moment the ramp voltage is frozen on the column.

The analog ramp, the switches and the pixel charging lie outside this block; only the switch-enable timing is produced. The next line can be loaded while the current line is sweeping, because the switches read only the storage register. A one-cycle done pulse marks the natural end of a sweep.

Top module: `ramp_switch_timer`

## Requirements
- R1: While reset is asserted and after it is released, every switch enable and the done output are 0 until the first line strobe.
- R2: Each clock with the load enable high writes the code input to one column of the input register. The first code after reset or after a line strobe goes to column 0 and each later code goes to the next column up. After column NUM_COLS-1 the next code goes to column 0 again.
- R3: A line strobe copies all input-register columns into the storage register and restarts the sweep count at 0. The count then rises by one per clock. Sweep cycle k (k = 0..63) is the k-th clock after the strobe edge.
- R4: In sweep cycle k a column whose stored code is v has its switch enable at 1 exactly when k < 63 - v. The switch is therefore on for 63 - v cycles and never turns on again within the sweep.
- R5: A column with stored code 63 has its switch enable at 0 from sweep cycle 0 onward.
- R6: A column with stored code 0 has its switch enable at 1 for sweep cycles 0 to 62 and at 0 in cycle 63.
- R7: In sweep cycle 63 every switch enable is 0. They all stay 0 after the sweep ends, until the next line strobe.
- R8: The done output is 1 for exactly one clock, in the cycle after sweep cycle 63, and is 0 in every sweep cycle.
- R9: Loading codes, with or without a sweep running, has no effect on the switch enables until the next line strobe.
- R10: A line strobe during a sweep starts a new sweep from count 0 with the newly stored codes. The interrupted sweep produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Write codeIn to the current input-register column |
| codeIn | input | 6 | Pixel code for the current column |
| lineStrobe | input | 1 | Capture the line into storage and restart the sweep |
| switchEn | output | NUM_COLS | Per-column sample-switch enable, 1 = following the ramp |
| sweepDone | output | 1 | One-cycle pulse after a sweep completes |

## Verification
A strobe sampled at a clock edge shows its effect in the next cycle: that cycle is sweep cycle 0, and the switch enables there already reflect the new storage. The done pulse arrives 64 cycles after that edge. The bench drives inputs just after a falling edge and samples outputs at the following falling edge, so sweep cycle k is observed exactly k falling edges after the strobe cycle ends. Every column is compared against 63 minus its code in every cycle. Codes loaded during a sweep are checked for effect only after the following strobe.

// File: rtl/ramp_timer_pkg.sv
package ramp_timer_pkg;
  localparam int CODE_W = 6;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  typedef logic [CODE_W-1:0] code_t;

  // Strobes and sweep state handed from control to datapath
  typedef struct packed {
    logic  writeCode;
    logic  captureLine;
    logic  sweeping;
    code_t count;
  } ctrl_strobes_t;
endpackage

// File: rtl/ramp_timer_ctrl.sv
module ramp_timer_ctrl
  import ramp_timer_pkg::*;
#(
  parameter int NUM_COLS = 8,
  localparam int IDX_W = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic             lineStrobe,
  output ctrl_strobes_t    strobes,
  output logic [IDX_W-1:0] colIdx,
  output logic             sweepDone
);
  localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(NUM_COLS - 1);

  code_t countQ;
  logic  sweepingQ;
  logic  doneQ;

  // Column pointer: advances per written code, wraps, restarts on strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colIdx <= '0;
    end else if (lineStrobe) begin
      colIdx <= '0;
    end else if (loadEn) begin
      colIdx <= (colIdx == LAST_COL) ? '0 : colIdx + 1'b1;
    end
  end

  // Shared sweep counter and its activity flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ    <= '0;
      sweepingQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= sweepingQ && (countQ == CODE_MAX) && !lineStrobe;
      if (lineStrobe) begin
        countQ    <= '0;
        sweepingQ <= 1'b1;
      end else if (sweepingQ) begin
        countQ <= countQ + 1'b1;
        if (countQ == CODE_MAX) begin
          sweepingQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strobes.writeCode   = loadEn;
    strobes.captureLine = lineStrobe;
    strobes.sweeping    = sweepingQ;
    strobes.count       = countQ;
  end

  assign sweepDone = doneQ;
endmodule

// File: rtl/ramp_timer_datapath.sv
module ramp_timer_datapath
  import ramp_timer_pkg::*;
#(
  parameter int NUM_COLS = 8,
  localparam int IDX_W = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [IDX_W-1:0]    colIdx,
  input  code_t               codeIn,
  output logic [NUM_COLS-1:0] switchEn
);
  for (genvar col = 0; col < NUM_COLS; col++) begin : g_col
    code_t inputQ;
    code_t storeQ;
    code_t turnOff;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inputQ <= '0;
        storeQ <= '0;
      end else begin
        if (strobes.writeCode && (colIdx == IDX_W'(col))) begin
          inputQ <= codeIn;
        end
        if (strobes.captureLine) begin
          storeQ <= inputQ;
        end
      end
    end

    // Switch opens at the count equal to the inverted code and stays open
    assign turnOff       = ~storeQ;
    assign switchEn[col] = strobes.sweeping && (strobes.count < turnOff);
  end
endmodule

// File: rtl/ramp_switch_timer.sv
module ramp_switch_timer
  import ramp_timer_pkg::*;
#(
  parameter int NUM_COLS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadEn,
  input  logic [CODE_W-1:0]   codeIn,
  input  logic                lineStrobe,
  output logic [NUM_COLS-1:0] switchEn,
  output logic                sweepDone
);
  localparam int IDX_W = $clog2(NUM_COLS);

  ctrl_strobes_t    ctrlStrobes;
  logic [IDX_W-1:0] colIdx;

  ramp_timer_ctrl #(.NUM_COLS(NUM_COLS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadEn     (loadEn),
    .lineStrobe (lineStrobe),
    .strobes    (ctrlStrobes),
    .colIdx     (colIdx),
    .sweepDone  (sweepDone)
  );

  ramp_timer_datapath #(.NUM_COLS(NUM_COLS)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (ctrlStrobes),
    .colIdx   (colIdx),
    .codeIn   (codeIn),
    .switchEn (switchEn)
  );
endmodule

// File: rtl/ramp_timer_checker.sv
module ramp_timer_checker
  import ramp_timer_pkg::*;
#(
  parameter int NUM_COLS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                lineStrobe,
  input logic [NUM_COLS-1:0] switchEn,
  input logic                sweepDone,
  input ctrl_strobes_t       strobes
);
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineStrobe |=> (strobes.sweeping && strobes.count == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sweeping && !lineStrobe && strobes.count != CODE_MAX)
      |=> (strobes.count == code_t'($past(strobes.count) + 1'b1)));

  assert_no_reopen_R4: assert property (@(posedge clk) disable iff (!rstN)
    !lineStrobe |=> ((switchEn & ~$past(switchEn)) == '0));

  assert_end_open_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sweeping && strobes.count == CODE_MAX) |-> (switchEn == '0));

  assert_idle_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sweeping |-> (switchEn == '0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |=> !sweepDone);

  assert_done_after_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> $past(strobes.sweeping && strobes.count == CODE_MAX && !lineStrobe));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> !strobes.sweeping);
endmodule

bind ramp_switch_timer ramp_timer_checker #(.NUM_COLS(NUM_COLS)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .lineStrobe (lineStrobe),
  .switchEn   (switchEn),
  .sweepDone  (sweepDone),
  .strobes    (ctrlStrobes)
);

// File: tb/test_ramp_switch_timer.sv
module test_ramp_switch_timer;
  localparam int NUM_COLS = 8;
  typedef logic [5:0] line_t [NUM_COLS];

  // Stimulus lines walked by the main loop; the expected on-time of each
  // column is 63 minus its code (R4..R6)
  localparam logic [5:0] LINE_TABLE [4][NUM_COLS] = '{
    '{6'd0,  6'd63, 6'd1,  6'd62, 6'd31, 6'd32, 6'd5,  6'd58},
    '{6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63},
    '{6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0},
    '{6'd10, 6'd20, 6'd30, 6'd40, 6'd50, 6'd60, 6'd2,  6'd61}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                loadEn = 1'b0;
  logic [5:0]          codeIn = '0;
  logic                lineStrobe = 1'b0;
  logic [NUM_COLS-1:0] switchEn;
  logic                sweepDone;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  ramp_switch_timer #(.NUM_COLS(NUM_COLS)) i_ramp_switch_timer (
    .clk        (clk),
    .rstN       (rstN),
    .loadEn     (loadEn),
    .codeIn     (codeIn),
    .lineStrobe (lineStrobe),
    .switchEn   (switchEn),
    .sweepDone  (sweepDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  task automatic loadLine(input line_t codes);
    for (int c = 0; c < NUM_COLS; c++) begin
      loadEn = 1'b1;
      codeIn = codes[c];
      @(negedge clk);
    end
    loadEn = 1'b0;
  endtask

  // Leaves the bench inside sweep cycle 0
  task automatic strobeLine();
    lineStrobe = 1'b1;
    @(negedge clk);
    lineStrobe = 1'b0;
  endtask

  task automatic checkSweep(input line_t codes, input int lastK,
                            input bit overlap, input line_t nxt);
    logic [NUM_COLS-1:0] expVec;
    for (int k = 0; k <= lastK; k++) begin
      for (int c = 0; c < NUM_COLS; c++) begin
        expVec[c] = (k < 63 - int'(codes[c]));
        check(switchEn[c] == expVec[c],
              (codes[c] == 6'd63) ? "R5" : (codes[c] == 6'd0) ? "R6" : "R4",
              $sformatf("column %0d cycle %0d", c, k), int'(switchEn[c]), int'(expVec[c]));
      end
      if (k == 0) check(switchEn == expVec, "R3", "captured line at cycle 0",
                        int'(switchEn), int'(expVec));
      if (k == 63) check(switchEn == '0, "R7", "all open at cycle 63", int'(switchEn), 0);
      check(sweepDone == 1'b0, "R8", $sformatf("done low in cycle %0d", k), int'(sweepDone), 0);
      if (overlap && k < NUM_COLS) begin
        loadEn = 1'b1;
        codeIn = nxt[k];
      end else begin
        loadEn = 1'b0;
      end
      @(negedge clk);
    end
    loadEn = 1'b0;
    if (lastK == 63) begin
      check(sweepDone == 1'b1, "R8", "done after cycle 63", int'(sweepDone), 1);
      @(negedge clk);
      check(sweepDone == 1'b0, "R8", "done is one cycle", int'(sweepDone), 0);
      for (int i = 0; i < 3; i++) begin
        check(switchEn == '0, "R7", "off after sweep", int'(switchEn), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    line_t lineA, lineB, lineC, zeroLine;
    for (int c = 0; c < NUM_COLS; c++) begin
      zeroLine[c] = 6'd0;
      lineA[c] = 6'(7 * c + 3);
      lineB[c] = 6'(63 - 5 * c);
      lineC[c] = 6'(9 * c);
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check(switchEn == '0, "R1", "switches in reset", int'(switchEn), 0);
    check(sweepDone == 1'b0, "R1", "done in reset", int'(sweepDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(switchEn == '0, "R1", "switches after reset", int'(switchEn), 0);

    // R9: loading without a strobe leaves switches idle
    loadLine(lineA);
    for (int i = 0; i < 4; i++) begin
      check(switchEn == '0, "R9", "load without strobe", int'(switchEn), 0);
      check(sweepDone == 1'b0, "R1", "no done before first strobe", int'(sweepDone), 0);
      @(negedge clk);
    end

    // Table walk: endpoints and mixed codes (R4, R5, R6, R7, R8)
    for (int v = 0; v < 4; v++) begin
      line_t row;
      for (int c = 0; c < NUM_COLS; c++) row[c] = LINE_TABLE[v][c];
      loadLine(row);
      strobeLine();
      checkSweep(row, 63, 1'b0, zeroLine);
    end

    // R9: next line loaded during a sweep, captured only by the next strobe
    loadLine(lineA);
    strobeLine();
    checkSweep(lineA, 63, 1'b1, lineB);
    strobeLine();
    checkSweep(lineB, 63, 1'b0, zeroLine);

    // R2: ninth code wraps onto column 0
    loadLine(lineC);
    loadEn = 1'b1;
    codeIn = 6'd50;
    @(negedge clk);
    loadEn = 1'b0;
    lineC[0] = 6'd50;
    strobeLine();
    checkSweep(lineC, 63, 1'b0, zeroLine);

    // R10: restart mid-sweep; R2: strobe reset the pointer to column 0
    loadLine(lineA);
    strobeLine();
    checkSweep(lineA, 19, 1'b1, lineB);
    strobeLine();
    checkSweep(lineB, 63, 1'b0, zeroLine);

    finishRun();
  end
endmodule